// File: doc/BRIEF.md
# Reference Pulse Ladder Timing Generator

This block is a cycle-accurate digital model of the timing source for a time-domain flash converter. Running from a fast tick clock, it divides time into conversion periods of a fixed number of ticks. Each period opens with a sampling pulse of selectable width. A reference clock edge follows, and it brings a one-tick active-low precharge strobe and a train of sixteen equally spaced one-tick reference pulses. The period ends with a short margin window in which every pulse output is quiet.

In the default configuration one tick stands for 0.5 ns and a period is 25 ticks (12.5 ns). The four width settings give sampling pulses of 1.5, 2, 2.5 and 3 ns. Adjacent reference pulses sit one tick apart, which models two stage delays of a 32-stage delay chain. The downstream comparators read the reference pulse bus, and the sampling front end reads the sample pulse. A width change is picked up only at a period boundary, so a period always keeps the width it started with.

Top module: `rlg_ref_ladder_gen`

## Requirements
- R1: While reset is asserted, and on the first clock after it, sample_pulse, ref_clk and every ref_pulse bit are low and precharge_n is high.
- R2: Within a period, sample_pulse is high on ticks 0 to W-1 and low otherwise, where W = 3 + width_sel (00 gives 3, 01 gives 4, 10 gives 5, 11 gives 6 ticks).
- R3: ref_clk is low on ticks 0 to 5, rises on tick 6, stays high through tick 22 and is low on ticks 23 and 24.
- R4: precharge_n is low on tick 6 of each period only and high on every other tick.
- R5: ref_pulse[i] is high on tick 7+i only, so at most one bit of the bus is high in any cycle and bit i+1 follows bit i on the next tick.
- R6: Each complete period holds exactly 16 reference pulse ticks. None of them coincides with sample_pulse, and ticks 23 and 24 carry no sample or reference pulse.
- R7: width_sel is sampled only on the clock edge that begins a period; a change during a period does not alter that period's sample width and applies from the next period.
- R8: When en is sampled low, all pulse outputs go inactive (precharge_n high) on that edge. The clock edge on which en is next sampled high begins a fresh period at tick 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock, one tick per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run enable; low holds all outputs inactive |
| width_sel | input | 2 | Sample pulse width select, W = 3 + width_sel ticks |
| sample_pulse | output | 1 | Input sampling pulse at the start of each period |
| ref_clk | output | 1 | Reference clock, high from tick 6 through tick 22 |
| precharge_n | output | 1 | Active-low precharge strobe on the reference edge tick |
| ref_pulse | output | 16 | Reference pulse bus, bit i high on tick 7+i |

## Verification
Two events that share a clock edge are the focus. The first is the period wrap together with a change of width_sel. The bench alters width_sel in mid-period and also right at tick 24, then counts the sample pulse width of the old and the new period against the width latched at each period's start. The second is a drop of enable in the middle of the reference train. Here the reference pulse and the forced idle state compete, and the bench checks that the bus clears on the very next tick and that a later re-enable restarts at tick 0 with the full sixteen pulses.

// File: rtl/rlg_pkg.sv
package rlg_pkg;
  localparam int TICKS_PER_PERIOD = 25;
  localparam int NUM_REFS         = 16;
  localparam int REF_EDGE_TICK    = 6;
  localparam int MIN_SAMPLE_TICKS = 3;
  localparam int SEL_W            = 2;

  // sample pulse length in ticks for a given select code
  function automatic int sample_ticks(input int min_ticks, input logic [SEL_W-1:0] sel);
    return min_ticks + int'(sel);
  endfunction

  // tick on which reference pulse idx is high
  function automatic int ref_tick(input int edge_tick, input int idx);
    return edge_tick + 1 + idx;
  endfunction
endpackage

// File: rtl/rlg_phase_counter.sv
module rlg_phase_counter #(
  parameter int TICKS   = rlg_pkg::TICKS_PER_PERIOD,
  parameter int PHASE_W = $clog2(TICKS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  output logic               active,
  output logic [PHASE_W-1:0] phase,
  output logic               period_start
);
  localparam logic [PHASE_W-1:0] LAST = PHASE_W'(TICKS - 1);

  logic at_last;
  assign at_last = active && (phase == LAST);
  // next edge begins tick 0 of a period
  assign period_start = en && (!active || at_last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      phase  <= '0;
    end else if (!en) begin
      active <= 1'b0;
      phase  <= '0;
    end else if (period_start) begin
      active <= 1'b1;
      phase  <= '0;
    end else begin
      phase  <= phase + 1'b1;
    end
  end
endmodule

// File: rtl/rlg_width_latch.sv
module rlg_width_latch #(
  parameter int SEL_W = rlg_pkg::SEL_W,
  parameter logic [SEL_W-1:0] RESET_SEL = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [SEL_W-1:0] sel_in,
  output logic [SEL_W-1:0] sel_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    sel_q <= RESET_SEL;
    else if (load) sel_q <= sel_in;
  end
endmodule

// File: rtl/rlg_pulse_decode.sv
module rlg_pulse_decode #(
  parameter int TICKS     = rlg_pkg::TICKS_PER_PERIOD,
  parameter int NREF      = rlg_pkg::NUM_REFS,
  parameter int EDGE_TICK = rlg_pkg::REF_EDGE_TICK,
  parameter int MIN_W     = rlg_pkg::MIN_SAMPLE_TICKS,
  parameter int SEL_W     = rlg_pkg::SEL_W,
  parameter int PHASE_W   = $clog2(TICKS)
) (
  input  logic               active,
  input  logic [PHASE_W-1:0] phase,
  input  logic [SEL_W-1:0]   sel_q,
  output logic               sample_pulse,
  output logic               ref_clk,
  output logic               precharge_n,
  output logic [NREF-1:0]    ref_pulse
);
  localparam int LAST_REF = rlg_pkg::ref_tick(EDGE_TICK, NREF - 1);

  int ph;
  assign ph = int'(phase);

  assign sample_pulse = active && (ph < rlg_pkg::sample_ticks(MIN_W, sel_q));
  assign ref_clk      = active && (ph >= EDGE_TICK) && (ph <= LAST_REF);
  assign precharge_n  = !(active && (ph == EDGE_TICK));

  for (genvar i = 0; i < NREF; i++) begin : g_ref
    assign ref_pulse[i] = active && (ph == rlg_pkg::ref_tick(EDGE_TICK, i));
  end
endmodule

// File: rtl/rlg_ref_ladder_gen.sv
module rlg_ref_ladder_gen #(
  parameter int TICKS     = rlg_pkg::TICKS_PER_PERIOD,
  parameter int NREF      = rlg_pkg::NUM_REFS,
  parameter int EDGE_TICK = rlg_pkg::REF_EDGE_TICK,
  parameter int MIN_W     = rlg_pkg::MIN_SAMPLE_TICKS,
  parameter int SEL_W     = rlg_pkg::SEL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [SEL_W-1:0] width_sel,
  output logic             sample_pulse,
  output logic             ref_clk,
  output logic             precharge_n,
  output logic [NREF-1:0]  ref_pulse
);
  localparam int PHASE_W = $clog2(TICKS);

  // named internal events, visible to the bound checker
  logic               run_active;
  logic [PHASE_W-1:0] run_phase;
  logic               period_start;
  logic [SEL_W-1:0]   width_q;

  rlg_phase_counter #(.TICKS(TICKS), .PHASE_W(PHASE_W)) u_phase (
    .clk          (clk),
    .rst_n        (rst_n),
    .en           (en),
    .active       (run_active),
    .phase        (run_phase),
    .period_start (period_start)
  );

  rlg_width_latch #(.SEL_W(SEL_W), .RESET_SEL(SEL_W'(1))) u_width (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (period_start),
    .sel_in (width_sel),
    .sel_q  (width_q)
  );

  rlg_pulse_decode #(
    .TICKS(TICKS), .NREF(NREF), .EDGE_TICK(EDGE_TICK),
    .MIN_W(MIN_W), .SEL_W(SEL_W), .PHASE_W(PHASE_W)
  ) u_decode (
    .active       (run_active),
    .phase        (run_phase),
    .sel_q        (width_q),
    .sample_pulse (sample_pulse),
    .ref_clk      (ref_clk),
    .precharge_n  (precharge_n),
    .ref_pulse    (ref_pulse)
  );
endmodule

// File: rtl/rlg_ref_ladder_gen_chk.sv
module rlg_ref_ladder_gen_chk #(
  parameter int NREF  = 16,
  parameter int SEL_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic             sample_pulse,
  input logic             ref_clk,
  input logic             precharge_n,
  input logic [NREF-1:0]  ref_pulse,
  input logic             run_active,
  input logic             period_start,
  input logic [SEL_W-1:0] width_q
);
  // R5: never two reference pulses at once
  a_r5_onehot_bus: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ref_pulse));

  // R6: sampling and reference pulses never coincide
  a_r6_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(sample_pulse && (ref_pulse != '0)));

  // R4: precharge strobe sits on the reference clock rising tick
  a_r4_prech_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
    !precharge_n |-> $rose(ref_clk));

  // R5: first reference pulse follows the precharge tick
  a_r5_first_after_prech: assert property (@(posedge clk) disable iff (!rst_n)
    (!precharge_n && en) |=> ref_pulse[0]);

  // R5: each pulse hands over to its neighbour one tick later
  for (genvar i = 0; i < NREF - 1; i++) begin : g_chain
    a_r5_chain: assert property (@(posedge clk) disable iff (!rst_n)
      (ref_pulse[i] && en) |=> ref_pulse[i+1]);
  end

  // R8: disable forces idle outputs on the next tick
  a_r8_idle_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!sample_pulse && !ref_clk && precharge_n && (ref_pulse == '0)));

  // R7: latched width only moves on a period boundary
  a_r7_width_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (run_active && !period_start) |=> $stable(width_q));
endmodule

bind rlg_ref_ladder_gen rlg_ref_ladder_gen_chk #(.NREF(NREF), .SEL_W(SEL_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .en           (en),
  .sample_pulse (sample_pulse),
  .ref_clk      (ref_clk),
  .precharge_n  (precharge_n),
  .ref_pulse    (ref_pulse),
  .run_active   (run_active),
  .period_start (period_start),
  .width_q      (width_q)
);

// File: tb/rlg_ref_ladder_gen_bench.sv
module rlg_ref_ladder_gen_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic [1:0]  width_sel = 2'd0;
  logic        sample_pulse, ref_clk, precharge_n;
  logic [15:0] ref_pulse;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit done = 0;

  // bench-side period model
  bit   m_active = 0;
  int   m_phase = 0;
  int   m_w = 4;
  bit   in_reset = 1;
  int   cnt_ref = 0, cnt_smp = 0;
  bit   saw_overlap = 0, margin_dirty = 0;
  string per_tag = "R2";

  always #4 clk = ~clk;  // 125 MHz

  rlg_ref_ladder_gen u_rlg_ref_ladder_gen (
    .clk(clk), .rst_n(rst_n), .en(en), .width_sel(width_sel),
    .sample_pulse(sample_pulse), .ref_clk(ref_clk),
    .precharge_n(precharge_n), .ref_pulse(ref_pulse)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1;
      bad++; total++;
      $display("FAIL watchdog: actual cycles=%0d expected <=100000", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input string tag, input string what, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h (tick %0d)", tag, what, act, exp, m_phase);
    end
  endtask

  task automatic compare();
    bit e_smp, e_rc, e_pn;
    logic [15:0] e_ref;
    string t1, t2, t3, t4;
    e_smp = m_active && (m_phase < m_w);
    e_rc  = m_active && (m_phase >= 6) && (m_phase <= 22);
    e_pn  = !(m_active && m_phase == 6);
    e_ref = '0;
    if (m_active && m_phase >= 7 && m_phase <= 22) e_ref[m_phase-7] = 1'b1;
    t1 = in_reset ? "R1" : (!m_active ? "R8" : "R2");
    t2 = in_reset ? "R1" : (!m_active ? "R8" : "R3");
    t3 = in_reset ? "R1" : (!m_active ? "R8" : "R4");
    t4 = in_reset ? "R1" : (!m_active ? "R8" : "R5");
    chk(t1, "sample_pulse", sample_pulse, e_smp);
    chk(t2, "ref_clk", ref_clk, e_rc);
    chk(t3, "precharge_n", precharge_n, e_pn);
    chk(t4, "ref_pulse", ref_pulse, e_ref);
    if (m_active) begin
      cnt_ref += $countones(ref_pulse);
      cnt_smp += int'(sample_pulse);
      if (sample_pulse && ref_pulse != 0) saw_overlap = 1;
      if (m_phase >= 23 && (sample_pulse || ref_pulse != 0)) margin_dirty = 1;
      if (m_phase == 24) begin
        chk("R6", "ref pulses per period", cnt_ref, 16);
        chk("R6", "sample/ref overlap", saw_overlap, 0);
        chk("R6", "margin activity", margin_dirty, 0);
        chk(per_tag, "sample width", cnt_smp, m_w);
        cnt_ref = 0; cnt_smp = 0; saw_overlap = 0; margin_dirty = 0;
      end
    end else begin
      cnt_ref = 0; cnt_smp = 0; saw_overlap = 0; margin_dirty = 0;
    end
  endtask

  // check the current cycle, then drive inputs and advance the model to the next edge
  task automatic step(input bit r, input bit e, input logic [1:0] s);
    @(negedge clk);
    compare();
    rst_n = r; en = e; width_sel = s;
    in_reset = !r;
    if (!r || !e) begin
      m_active = 0; m_phase = 0;
    end else if (!m_active || m_phase == 24) begin
      if (m_active && per_tag == "R7" && m_phase == 24) per_tag = "R7";
      m_active = 1; m_phase = 0; m_w = 3 + int'(s);
    end else begin
      m_phase++;
    end
  endtask

  task automatic run_to_phase(input int ph, input logic [1:0] s);
    while (!(m_active && m_phase == ph)) step(1, 1, s);
  endtask

  initial begin
    // R1: reset state, held for several cycles with en high
    for (int i = 0; i < 4; i++) step(0, 1, 2'd3);
    step(1, 0, 2'd1);
    step(1, 0, 2'd1);

    // R2..R6: every width setting over several periods
    for (int s = 0; s < 4; s++) begin
      for (int n = 0; n < 3 * 25; n++) step(1, 1, 2'(s));
    end

    // R7: change width in mid-period, old width must hold for this period
    per_tag = "R7";
    run_to_phase(10, 2'd0);
    step(1, 1, 2'd3);
    run_to_phase(23, 2'd3);
    step(1, 1, 2'd3);              // edge leaving tick 23
    step(1, 1, 2'd2);              // change lands on the wrap edge
    for (int n = 0; n < 2 * 25; n++) step(1, 1, 2'd2);
    run_to_phase(24, 2'd0);
    step(1, 1, 2'd0);
    for (int n = 0; n < 25; n++) step(1, 1, 2'd0);
    per_tag = "R2";

    // R8: drop enable in the middle of the reference train
    run_to_phase(12, 2'd1);
    step(1, 0, 2'd1);
    for (int n = 0; n < 3; n++) step(1, 0, 2'd1);
    for (int n = 0; n < 2 * 25 + 3; n++) step(1, 1, 2'd1);

    // R8: drop enable exactly at the wrap tick
    run_to_phase(24, 2'd2);
    step(1, 0, 2'd2);
    step(1, 1, 2'd2);
    for (int n = 0; n < 30; n++) step(1, 1, 2'd2);

    // R1: reset in the middle of a period
    run_to_phase(8, 2'd3);
    step(0, 1, 2'd3);
    step(0, 1, 2'd3);
    step(1, 1, 2'd3);
    for (int n = 0; n < 2 * 25; n++) step(1, 1, 2'd3);
    step(1, 0, 2'd0);
    step(1, 0, 2'd0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule